// File: doc/BRIEF.md
# Three-Phase Center-Aligned Complementary PWM Generator

This block drives a three-phase bridge. One shared counter moves up and down between a floor of twice the programmed dead time and a programmable period value. This produces a triangle carrier. Each phase compares the carrier with its own duty value. The result is a level that is high while the carrier sits at or above that value. The level then passes through a dead-band stage, which produces a positive output and a negative output. The two outputs never overlap, and they are separated by the dead time.

Duty values are written into per-phase shadow registers. A shadow value is copied into the compare register only at the peak of the carrier, or at any time while the generator is stopped. A duty of zero gives a continuous positive output. A duty above the period gives a continuous negative output. An active-low external clear pin passes through a two-flop synchronizer. Its falling edge restarts the carrier at the floor, counting upward.

Top module: `pwm3_complementary`

## Requirements
- R1: While running with period > 2·dead_time, `count_out` changes by exactly one on every clock. Rising counts (`count_up` = 1) reverse at the first count that is at or above `period`. Falling counts (`count_up` = 0) reverse at the first count that is at or below 2·dead_time. The carrier therefore visits every value from 2·dead_time to `period` and back.
- R2: A cycle with bit i of `duty_wr_en` high stores `duty_wr_data` into the shadow of phase i (bit 0 = U, 1 = V, 2 = W). The compare value of a phase takes its shadow only on the clock that reverses the carrier at the peak, or on every clock while `run_en` is low. A write in mid-period does not change the outputs before that peak.
- R3: The level of phase i is high when the count is at or above its compare value. The outputs are registered one clock after the count that produced them. With a long enough level, the positive output is high for (high-level cycles − dead_time) of each carrier period, and the negative output is high for (low-level cycles − dead_time).
- R4: A compare value of 0 keeps the positive output of that phase high and its negative output low for the whole period.
- R5: A compare value greater than `period` keeps the positive output of that phase low and its negative output high for the whole period.
- R6: A high-to-low change on `ext_clr_n` that is present before clock edge k sets `count_out` to 2·dead_time with `count_up` = 1 after edge k+2. Counting then continues upward. Holding the pin low causes no further reload. The clear takes precedence over counting and over the stopped hold.
- R7: When a phase's level changes, both outputs of that phase are low for exactly dead_time clocks, and then the new side turns on. A change during that wait starts the wait again. The positive and negative outputs of a phase are never high together. With dead_time = 0, the outputs switch directly.
- R8: While `run_en` is low, the count and direction hold and all six outputs are low from the next clock on. After `run_en` returns high, all outputs stay low for dead_time clocks before they follow their levels.
- R9: When `period` ≤ 2·dead_time, the count is held at 2·dead_time with `count_up` = 1.
- R10: Reset loads the count with 2·dead_time counting up, sets every output low, and sets every shadow and compare value to all ones (full off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low holds the carrier and idles the outputs |
| period | input | CNT_W | Carrier peak value |
| dead_time | input | TD_W | Dead time in clocks; the floor is twice this value |
| duty_wr_en | input | NUM_PH | Per-phase shadow write strobes |
| duty_wr_data | input | CNT_W | Duty value written by the strobes |
| ext_clr_n | input | 1 | Asynchronous active-low carrier restart pin |
| pos_out | output | NUM_PH | Positive-side drive per phase |
| neg_out | output | NUM_PH | Negative-side drive per phase |
| count_out | output | CNT_W | Current carrier count |
| count_up | output | 1 | High while the carrier is rising |

## Verification
The phases are loaded with a duty of zero, a duty above the period and a mid-range duty. These separate the two full-scale cases from real comparison, and per-window on-time counts separate dead-time removal from compare errors. A shadow write made while the carrier falls, followed by a look at the output just before the peak, separates peak-only transfer from immediate transfer. A run with zero dead time shows that the floor drops to zero and that the switching is direct. A clear pulse held low checks the synchronizer latency and shows that the reload happens only on the edge. Stop/restart and a period at or below the floor cover the hold and pinned cases, while a behavioural model is compared on every clock.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;

    // Direction of the triangle carrier.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // What the carrier does on the coming clock edge.
    typedef enum logic [2:0] {
        ACT_RELOAD,   // jump to the floor, rising
        ACT_HOLD,     // keep count and direction
        ACT_RISE,     // +1, rising
        ACT_FALL,     // -1, falling
        ACT_PEAK,     // reverse at the top: -1, falling, compare transfer
        ACT_VALLEY    // reverse at the floor: +1, rising
    } cnt_act_e;

    // One complementary output pair.
    typedef struct packed {
        logic pos;
        logic neg;
    } pair_t;

    localparam pair_t PAIR_IDLE = '{pos: 1'b0, neg: 1'b0};

    // Drive pair for a settled level.
    function automatic pair_t pair_for(input logic level);
        pair_t p;
        p.pos = level;
        p.neg = ~level;
        return p;
    endfunction

endpackage

// File: rtl/pwm3_clr_sync.sv
`timescale 1ns/1ps
module pwm3_clr_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall_evt
);
    // Two synchronizing flops plus one history flop for edge detection.
    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            hist_q <= 1'b1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign fall_evt = hist_q & ~sync_q;

    // R6: one event per falling edge, never two in a row
    a_r6_single_event: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> !fall_evt);

endmodule

// File: rtl/pwm3_counter.sv
`timescale 1ns/1ps
module pwm3_counter
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TD_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] period,
    input  logic [TD_W-1:0]  dead_time,
    input  logic             clr_evt,
    output logic [CNT_W-1:0] cnt_o,
    output dir_e             dir_o,
    output logic             peak_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] floor_v;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    dir_e             dir_q;
    dir_e             dir_d;
    cnt_act_e         act;
    logic             cfg_ok;

    // Floor of the carrier: twice the dead time.
    assign floor_v = CNT_W'({dead_time, 1'b0});
    assign cfg_ok  = (period > floor_v);

    // Action select: clear first, then an unusable period, then stop, then sweep.
    always_comb begin
        if (clr_evt || !cfg_ok) begin
            act = ACT_RELOAD;
        end else if (!run_en) begin
            act = ACT_HOLD;
        end else if (dir_q == DIR_UP) begin
            act = (cnt_q >= period) ? ACT_PEAK : ACT_RISE;
        end else begin
            act = (cnt_q <= floor_v) ? ACT_VALLEY : ACT_FALL;
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        unique case (act)
            ACT_RELOAD: begin cnt_d = floor_v;     dir_d = DIR_UP;   end
            ACT_HOLD:   begin cnt_d = cnt_q;       dir_d = dir_q;    end
            ACT_RISE:   begin cnt_d = cnt_q + ONE; dir_d = DIR_UP;   end
            ACT_VALLEY: begin cnt_d = cnt_q + ONE; dir_d = DIR_UP;   end
            ACT_FALL:   begin cnt_d = cnt_q - ONE; dir_d = DIR_DOWN; end
            ACT_PEAK:   begin cnt_d = cnt_q - ONE; dir_d = DIR_DOWN; end
            default:    begin cnt_d = floor_v;     dir_d = DIR_UP;   end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= floor_v;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt_o    = cnt_q;
    assign dir_o    = dir_q;
    assign peak_evt = (act == ACT_PEAK);

    // R1: inside the sweep range the count moves by exactly one
    a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
        (run_en && !clr_evt && cfg_ok && cnt_q >= floor_v && cnt_q <= period)
        |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));

    // R6: a clear event restarts at the floor, rising
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> (cnt_q == $past(floor_v) && dir_q == DIR_UP));

    // R8: stopped carrier holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !clr_evt && cfg_ok) |=> ($stable(cnt_q) && $stable(dir_q)));

    // R9: unusable period pins the count to the floor
    a_r9_pinned: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> (cnt_q == $past(floor_v) && dir_q == DIR_UP));

endmodule

// File: rtl/pwm3_duty_slot.sv
`timescale 1ns/1ps
module pwm3_duty_slot #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             peak_evt,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cnt,
    output logic             level_o
);
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] cmp_q;
    logic             xfer;

    // Transfer at the peak, or freely while stopped.
    assign xfer = peak_evt | ~run_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '1;
            cmp_q    <= '1;
        end else begin
            if (wr_en) begin
                shadow_q <= wr_data;
            end
            if (xfer) begin
                cmp_q <= shadow_q;
            end
        end
    end

    // Zero always passes (count never negative); above the peak never passes.
    assign level_o = (cnt >= cmp_q);

    // R2: compare register takes the shadow only on transfer cycles
    a_r2_transfer: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (cmp_q == $past(shadow_q)));

    a_r2_no_midperiod: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(cmp_q));

endmodule

// File: rtl/pwm3_deadband.sv
`timescale 1ns/1ps
module pwm3_deadband
    import pwm3_pkg::*;
#(
    parameter int unsigned TD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_en,
    input  logic [TD_W-1:0] dead_time,
    input  logic            level_i,
    output logic            pos_o,
    output logic            neg_o
);
    localparam logic [TD_W-1:0] TD_ONE = TD_W'(1);

    logic            lvl_q;
    logic [TD_W-1:0] wait_q;
    pair_t           out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            wait_q <= '0;
            out_q  <= PAIR_IDLE;
        end else if (!run_en) begin
            // Idle: track the level and arm a full wait for the restart.
            lvl_q  <= level_i;
            wait_q <= dead_time;
            out_q  <= PAIR_IDLE;
        end else if (level_i != lvl_q) begin
            lvl_q <= level_i;
            if (dead_time == '0) begin
                wait_q <= '0;
                out_q  <= pair_for(level_i);
            end else begin
                wait_q <= dead_time - TD_ONE;
                out_q  <= PAIR_IDLE;
            end
        end else if (wait_q != '0) begin
            wait_q <= wait_q - TD_ONE;
            out_q  <= PAIR_IDLE;
        end else begin
            out_q <= pair_for(lvl_q);
        end
    end

    assign pos_o = out_q.pos;
    assign neg_o = out_q.neg;

    // R7: never both sides on
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pos_o && neg_o));

    // R7: with a nonzero dead time the other side cannot follow at once
    a_r7_gap_pos: assert property (@(posedge clk) disable iff (rst)
        (dead_time != '0 && $fell(pos_o)) |-> !neg_o);

    a_r7_gap_neg: assert property (@(posedge clk) disable iff (rst)
        (dead_time != '0 && $fell(neg_o)) |-> !pos_o);

    // R8: stopped means idle outputs on the next clock
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!pos_o && !neg_o));

endmodule

// File: rtl/pwm3_complementary.sv
`timescale 1ns/1ps
module pwm3_complementary
    import pwm3_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned TD_W   = 8,
    parameter int unsigned NUM_PH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [CNT_W-1:0]  period,
    input  logic [TD_W-1:0]   dead_time,
    input  logic [NUM_PH-1:0] duty_wr_en,
    input  logic [CNT_W-1:0]  duty_wr_data,
    input  logic              ext_clr_n,
    output logic [NUM_PH-1:0] pos_out,
    output logic [NUM_PH-1:0] neg_out,
    output logic [CNT_W-1:0]  count_out,
    output logic              count_up
);
    logic             clr_evt;
    logic             peak_evt;
    logic [CNT_W-1:0] cnt;
    dir_e             dir;
    logic [NUM_PH-1:0] level;

    pwm3_clr_sync u_clr (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (ext_clr_n),
        .fall_evt (clr_evt)
    );

    pwm3_counter #(
        .CNT_W (CNT_W),
        .TD_W  (TD_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .period    (period),
        .dead_time (dead_time),
        .clr_evt   (clr_evt),
        .cnt_o     (cnt),
        .dir_o     (dir),
        .peak_evt  (peak_evt)
    );

    for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_phase
        pwm3_duty_slot #(
            .CNT_W (CNT_W)
        ) u_duty (
            .clk      (clk),
            .rst      (rst),
            .run_en   (run_en),
            .peak_evt (peak_evt),
            .wr_en    (duty_wr_en[ph]),
            .wr_data  (duty_wr_data),
            .cnt      (cnt),
            .level_o  (level[ph])
        );

        pwm3_deadband #(
            .TD_W (TD_W)
        ) u_db (
            .clk       (clk),
            .rst       (rst),
            .run_en    (run_en),
            .dead_time (dead_time),
            .level_i   (level[ph]),
            .pos_o     (pos_out[ph]),
            .neg_o     (neg_out[ph])
        );
    end

    assign count_out = cnt;
    assign count_up  = (dir == DIR_UP);

    // R10: outputs are idle in the cycle after reset
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (pos_out == '0 && neg_out == '0 && count_up));

endmodule

// File: tb/pwm3_complementary_tb.sv
`timescale 1ns/1ps
module pwm3_complementary_tb;
    localparam int CW = 16;
    localparam int TW = 8;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic [CW-1:0] period = 16'd10;
    logic [TW-1:0] dead_time = 8'd2;
    logic [NP-1:0] duty_wr_en = '0;
    logic [CW-1:0] duty_wr_data = '0;
    logic          ext_clr_n = 1'b1;
    logic [NP-1:0] pos_out;
    logic [NP-1:0] neg_out;
    logic [CW-1:0] count_out;
    logic          count_up;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pwm3_complementary #(.CNT_W(CW), .TD_W(TW), .NUM_PH(NP)) u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .period(period),
        .dead_time(dead_time), .duty_wr_en(duty_wr_en),
        .duty_wr_data(duty_wr_data), .ext_clr_n(ext_clr_n),
        .pos_out(pos_out), .neg_out(neg_out),
        .count_out(count_out), .count_up(count_up)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference, updated at each rising edge
    int m_cnt, m_up, m_pin1, m_pin2, m_pin3;
    int m_shadow[NP], m_cmp[NP], m_lvl[NP], m_wait[NP], m_pos[NP], m_neg[NP];
    int m_floor, m_raw[NP];
    bit m_fall, m_peak;

    always @(posedge clk) begin
        m_floor = 2 * int'(dead_time);
        if (rst) begin
            m_cnt = m_floor; m_up = 1;
            m_pin1 = 1; m_pin2 = 1; m_pin3 = 1;
            for (int i = 0; i < NP; i++) begin
                m_shadow[i] = 65535; m_cmp[i] = 65535;
                m_lvl[i] = 0; m_wait[i] = 0; m_pos[i] = 0; m_neg[i] = 0;
            end
        end else begin
            m_fall = (m_pin3 == 1) && (m_pin2 == 0);
            m_pin3 = m_pin2; m_pin2 = m_pin1; m_pin1 = int'(ext_clr_n);
            for (int i = 0; i < NP; i++) m_raw[i] = (m_cnt >= m_cmp[i]) ? 1 : 0;
            m_peak = 0;
            if (m_fall || int'(period) <= m_floor) begin
                m_cnt = m_floor; m_up = 1;
            end else if (!run_en) begin
                m_cnt = m_cnt;
            end else if (m_up == 1) begin
                if (m_cnt >= int'(period)) begin m_peak = 1; m_up = 0; m_cnt--; end
                else m_cnt++;
            end else begin
                if (m_cnt <= m_floor) begin m_up = 1; m_cnt++; end
                else m_cnt--;
            end
            for (int i = 0; i < NP; i++) begin
                if (!run_en || m_peak) m_cmp[i] = m_shadow[i];
                if (duty_wr_en[i]) m_shadow[i] = int'(duty_wr_data);
                if (!run_en) begin
                    m_lvl[i] = m_raw[i]; m_wait[i] = int'(dead_time);
                    m_pos[i] = 0; m_neg[i] = 0;
                end else if (m_raw[i] != m_lvl[i]) begin
                    m_lvl[i] = m_raw[i];
                    if (dead_time == 0) begin
                        m_wait[i] = 0; m_pos[i] = m_raw[i]; m_neg[i] = 1 - m_raw[i];
                    end else begin
                        m_wait[i] = int'(dead_time) - 1; m_pos[i] = 0; m_neg[i] = 0;
                    end
                end else if (m_wait[i] != 0) begin
                    m_wait[i]--; m_pos[i] = 0; m_neg[i] = 0;
                end else begin
                    m_pos[i] = m_lvl[i]; m_neg[i] = 1 - m_lvl[i];
                end
            end
        end
    end

    // ---------------- per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            int ep, en;
            ep = 0; en = 0;
            for (int i = 0; i < NP; i++) begin
                ep |= m_pos[i] << i;
                en |= m_neg[i] << i;
            end
            chk("R1 model count", int'(count_out), m_cnt);
            chk("R1 model direction", int'(count_up), m_up);
            chk("R3 R7 model positive outputs", int'(pos_out), ep);
            chk("R3 R7 model negative outputs", int'(neg_out), en);
            chk("R7 exclusive sides", int'(pos_out & neg_out), 0);
        end
    end

    // ---------------- watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_err++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- helpers
    task automatic wr(input int ph, input int val);
        duty_wr_en = '0;
        duty_wr_en[ph] = 1'b1;
        duty_wr_data = CW'(val);
        @(negedge clk);
        duty_wr_en = '0;
    endtask

    task automatic wait_cnt(input int val, input int up);
        int k;
        k = 0;
        while (!(int'(count_out) == val && int'(count_up) == up) && k < 200) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic window(input int ph, input int n, output int pc, output int nc);
        pc = 0; nc = 0;
        repeat (n) begin
            @(negedge clk);
            pc += int'(pos_out[ph]);
            nc += int'(neg_out[ph]);
        end
    endtask

    // ---------------- directed sequence
    initial begin
        int pc, nc, mn, mx, held;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 reset count", int'(count_out), 4);
        chk("R10 reset direction", int'(count_up), 1);
        chk("R10 reset pos", int'(pos_out), 0);
        chk("R10 reset neg", int'(neg_out), 0);
        rst = 1'b0;
        @(negedge clk);

        // Load duties while stopped (R2 stopped transfer)
        wr(0, 0);
        wr(1, 16'hFFFF);
        wr(2, 7);
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        repeat (40) @(negedge clk);

        // R1 sweep bounds
        mn = 1000; mx = -1;
        repeat (24) begin
            @(negedge clk);
            if (int'(count_out) < mn) mn = int'(count_out);
            if (int'(count_out) > mx) mx = int'(count_out);
        end
        chk("R1 sweep minimum", mn, 4);
        chk("R1 sweep maximum", mx, 10);

        // R4 full on, R5 full off
        window(0, 12, pc, nc);
        chk("R4 duty zero pos", pc, 12);
        chk("R4 duty zero neg", nc, 0);
        window(1, 12, pc, nc);
        chk("R5 duty above period pos", pc, 0);
        chk("R5 duty above period neg", nc, 12);
        // R3 mid duty, R7 dead time removed twice per period
        window(2, 12, pc, nc);
        chk("R3 duty 7 pos on-time", pc, 5);
        chk("R3 duty 7 neg on-time", nc, 3);
        chk("R7 dead cycles per period", 12 - pc - nc, 4);

        // R2 mid-period write waits for the peak
        wait_cnt(5, 0);
        wr(2, 16'hFFFF);
        wait_cnt(10, 1);
        chk("R2 old duty kept before peak", int'(pos_out[2]), 1);
        repeat (16) @(negedge clk);
        window(2, 12, pc, nc);
        chk("R2 new duty after peak pos", pc, 0);
        chk("R2 new duty after peak neg", nc, 12);

        // R7 zero dead time: direct switching, floor at zero
        dead_time = 8'd0;
        wr(2, 3);
        repeat (50) @(negedge clk);
        window(2, 20, pc, nc);
        chk("R7 zero dead time pos", pc, 15);
        chk("R7 zero dead time neg", nc, 5);
        chk("R7 zero dead time coverage", pc + nc, 20);
        dead_time = 8'd2;
        repeat (40) @(negedge clk);

        // R6 external clear
        wait_cnt(8, 1);
        ext_clr_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 no reload before sync", int'(count_out), 10);
        @(negedge clk);
        chk("R6 reload to floor", int'(count_out), 4);
        chk("R6 reload rising", int'(count_up), 1);
        repeat (6) @(negedge clk);
        chk("R6 held low no second reload", int'(count_out), 10);
        ext_clr_n = 1'b1;
        repeat (20) @(negedge clk);

        // R8 stop and restart
        run_en = 1'b0;
        @(negedge clk);
        chk("R8 stopped pos idle", int'(pos_out), 0);
        chk("R8 stopped neg idle", int'(neg_out), 0);
        held = int'(count_out);
        repeat (5) @(negedge clk);
        chk("R8 stopped count holds", int'(count_out), held);
        run_en = 1'b1;
        @(negedge clk);
        chk("R8 restart wait 1", int'(pos_out | neg_out), 0);
        @(negedge clk);
        chk("R8 restart wait 2", int'(pos_out | neg_out), 0);
        @(negedge clk);
        chk("R8 restart phase U on", int'(pos_out[0]), 1);
        repeat (20) @(negedge clk);

        // R9 period at or below the floor
        period = 16'd4;
        repeat (3) @(negedge clk);
        chk("R9 pinned count", int'(count_out), 4);
        chk("R9 pinned direction", int'(count_up), 1);
        period = 16'd3;
        repeat (3) @(negedge clk);
        chk("R9 pinned below floor", int'(count_out), 4);
        period = 16'd10;
        repeat (30) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule